// File: doc/BRIEF.md
# Power State Sequencer with Soft Mute

This controller chooses the power state of an audio output path from three observations: whether the master clock is alive, whether the serial bit clock is toggling, and the level of an active-low mute input. A watchdog outside the block watches the master clock and reports the result on `mclk_alive`. The raw bit clock is fed in directly. A detector inside the block, clocked by the system clock, decides whether the bit clock is running.

The block produces an unsigned gain coefficient for the sample path. The gain is applied to each sample, and `sample_valid` marks each sample.

Leaving the Enabled state is never abrupt. The gain first falls linearly to zero over a fixed number of samples. Only after the gain reaches zero does the sequencer settle in Standby. Releasing mute, while the bit clock runs, restores full gain in a single step. Losing the master clock drops everything to Off at once.

The FSM has four internal states: `PS_OFF`, `PS_STANDBY`, `PS_ENABLED` and `PS_FADING`. `PS_FADING` is the ramp-down phase and is reported at the port as Enabled. The named transitions are:
- **power-up-play**: Off to Enabled.
- **power-up-quiet**: Off to Standby.
- **wake**: Standby to Enabled.
- **fade-start**: Enabled to Fading.
- **fade-abort**: Fading to Enabled.
- **fade-done**: Fading to Standby.
- **clock-loss**: any state to Off.

Top module: `pwr_seq_softmute`

## Requirements
- R1: During and after reset, with no clocks reported, `pwr_state` is 0 (Off) and `gain` is 0.
- R2: From Off, when `mclk_alive` is 1 and the bit clock is running, the next state is Enabled if `mute_n` is 1, or Standby if `mute_n` is 0. In Enabled, `gain` is 65535 (full scale).
- R3: The bit clock is declared running after a synchronized edge. It is declared stopped after BCLK_TIMEOUT (default 64) system clocks without an edge. While it is stopped, Off is held.
- R4: Standby moves to Enabled only when `mute_n` is 1 and the bit clock is running. Losing the bit clock in Standby keeps the block in Standby.
- R5: In Enabled, mute_n = 0 or a stopped bit clock starts the ramp. After k samples of the ramp, `gain` equals 65535 − floor(k·65535/800). This reaches exactly 0 on sample 800. A new ramp always starts from full scale.
- R6: Standby is entered from a ramp only on the cycle after `gain` has reached 0, never directly from Enabled.
- R7: Releasing mute (`mute_n` = 1) with the bit clock running during a ramp returns `gain` to 65535 and the state to Enabled on the next cycle.
- R8: `mclk_alive` = 0 forces Off, with `gain` 0, on the next cycle from any state.
- R9: `sample_valid` has no effect on `gain` outside a ramp (it stays 65535 in Enabled and 0 in Standby).
- R10: `pwr_state` encodes 0 = Off, 1 = Standby, 2 = Enabled. The ramp is reported as 2, and the value 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mclk_alive | input | 1 | Master clock present, from an external watchdog |
| bclk_in | input | 1 | Raw bit clock, sampled by the system clock |
| mute_n | input | 1 | Active-low mute request |
| sample_valid | input | 1 | One-cycle strobe per audio sample |
| gain | output | GAIN_W (16) | Per-sample gain coefficient, 65535 = full scale |
| pwr_state | output | 2 | 0 Off, 1 Standby, 2 Enabled |

## Verification
The assertions check on every cycle:
- the gain values tied to each state,
- that the ramp never rises and moves only on a sample,
- the one-cycle fall to Off on master clock loss,
- that Standby is never reached from Enabled, or from a ramp whose gain is still above zero.

Only the bench scenarios can show:
- the exact gain value after each of the 800 samples,
- restart from full scale after an aborted ramp,
- the bit-clock timeout window measured from the last edge,
- that Standby holds through bit-clock loss until mute is released and the bit clock returns.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
    typedef enum logic [1:0] {
        PS_OFF     = 2'd0,
        PS_STANDBY = 2'd1,
        PS_ENABLED = 2'd2,
        PS_FADING  = 2'd3
    } pwr_state_e;

    localparam logic [1:0] REP_OFF     = 2'd0;
    localparam logic [1:0] REP_STANDBY = 2'd1;
    localparam logic [1:0] REP_ENABLED = 2'd2;
endpackage

// File: rtl/bclk_activity_mon.sv
module bclk_activity_mon #(
    parameter int TIMEOUT     = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_raw,
    output logic running
);
    localparam int CNT_W = $clog2(TIMEOUT + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT - 1);

    logic [SYNC_STAGES:0] sh_q;
    logic [CNT_W-1:0]     idle_q;
    logic                 edge_seen;

    assign edge_seen = sh_q[SYNC_STAGES] ^ sh_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q    <= '0;
            idle_q  <= '0;
            running <= 1'b0;
        end else begin
            sh_q <= {sh_q[SYNC_STAGES-1:0], bclk_raw};
            if (edge_seen) begin
                idle_q  <= '0;
                running <= 1'b1;
            end else if (idle_q == LIMIT) begin
                running <= 1'b0;
            end else begin
                idle_q <= idle_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp #(
    parameter int GAIN_W   = 16,
    parameter int RAMP_LEN = 800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load_full,
    input  logic              step,
    output logic [GAIN_W-1:0] gain,
    output logic              at_zero
);
    localparam longint FULL_I   = (longint'(1) << GAIN_W) - 1;
    localparam longint STEP_INT = FULL_I / RAMP_LEN;
    localparam longint STEP_REM = FULL_I % RAMP_LEN;
    localparam int     ACC_W    = $clog2(RAMP_LEN) + 1;

    localparam logic [GAIN_W-1:0] FULL   = {GAIN_W{1'b1}};
    localparam logic [GAIN_W-1:0] STEP_V = GAIN_W'(STEP_INT);
    localparam logic [ACC_W:0]    REM_V  = (ACC_W+1)'(STEP_REM);
    localparam logic [ACC_W:0]    LEN_V  = (ACC_W+1)'(RAMP_LEN);

    logic [ACC_W-1:0]  acc_q;
    logic [ACC_W:0]    acc_sum;
    logic              carry;
    logic [GAIN_W-1:0] dec;

    // Bresenham-style split of FULL/RAMP_LEN into integer and fractional steps
    assign acc_sum = {1'b0, acc_q} + REM_V;
    assign carry   = (acc_sum >= LEN_V);
    assign dec     = STEP_V + GAIN_W'(carry);
    assign at_zero = (gain == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain  <= '0;
            acc_q <= '0;
        end else if (clear) begin
            gain  <= '0;
            acc_q <= '0;
        end else if (load_full) begin
            gain  <= FULL;
            acc_q <= '0;
        end else if (step) begin
            acc_q <= carry ? ACC_W'(acc_sum - LEN_V) : ACC_W'(acc_sum);
            gain  <= (gain > dec) ? gain - dec : '0;
        end
    end
endmodule

// File: rtl/power_fsm.sv
module power_fsm
    import pwr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mclk_alive,
    input  logic       bclk_running,
    input  logic       mute_n,
    input  logic       sample_valid,
    input  logic       gain_zero,
    output pwr_state_e state_q,
    output logic       ramp_clear,
    output logic       ramp_load,
    output logic       ramp_step
);
    pwr_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_OFF:     if (bclk_running) state_d = mute_n ? PS_ENABLED : PS_STANDBY;
            PS_STANDBY: if (mute_n && bclk_running) state_d = PS_ENABLED;
            PS_ENABLED: if (!mute_n || !bclk_running) state_d = PS_FADING;
            PS_FADING: begin
                if (mute_n && bclk_running) state_d = PS_ENABLED;
                else if (gain_zero)         state_d = PS_STANDBY;
            end
        endcase
        if (!mclk_alive) state_d = PS_OFF;
    end

    always_comb begin
        ramp_clear = (state_d == PS_OFF) || (state_d == PS_STANDBY);
        ramp_load  = (state_d == PS_ENABLED);
        ramp_step  = (state_q == PS_FADING) && (state_d == PS_FADING) && sample_valid;
    end
endmodule

// File: rtl/pwr_seq_softmute.sv
module pwr_seq_softmute
    import pwr_seq_pkg::*;
#(
    parameter int GAIN_W       = 16,
    parameter int RAMP_LEN     = 800,
    parameter int BCLK_TIMEOUT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mclk_alive,
    input  logic              bclk_in,
    input  logic              mute_n,
    input  logic              sample_valid,
    output logic [GAIN_W-1:0] gain,
    output logic [1:0]        pwr_state
);
    pwr_state_e fsm_state;
    logic       bclk_running;
    logic       ramp_clear, ramp_load, ramp_step, gain_zero;

    bclk_activity_mon #(.TIMEOUT(BCLK_TIMEOUT), .SYNC_STAGES(2)) u_bmon (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk_raw (bclk_in),
        .running  (bclk_running)
    );

    power_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .mclk_alive   (mclk_alive),
        .bclk_running (bclk_running),
        .mute_n       (mute_n),
        .sample_valid (sample_valid),
        .gain_zero    (gain_zero),
        .state_q      (fsm_state),
        .ramp_clear   (ramp_clear),
        .ramp_load    (ramp_load),
        .ramp_step    (ramp_step)
    );

    soft_mute_ramp #(.GAIN_W(GAIN_W), .RAMP_LEN(RAMP_LEN)) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (ramp_clear),
        .load_full (ramp_load),
        .step      (ramp_step),
        .gain      (gain),
        .at_zero   (gain_zero)
    );

    always_comb begin
        unique case (fsm_state)
            PS_OFF:     pwr_state = REP_OFF;
            PS_STANDBY: pwr_state = REP_STANDBY;
            PS_ENABLED,
            PS_FADING:  pwr_state = REP_ENABLED;
        endcase
    end
endmodule

// File: rtl/pwr_seq_checker.sv
module pwr_seq_checker
    import pwr_seq_pkg::*;
#(
    parameter int GAIN_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mclk_alive,
    input logic              mute_n,
    input logic              sample_valid,
    input logic [GAIN_W-1:0] gain,
    input logic [1:0]        pwr_state,
    input pwr_state_e        fsm_state
);
    localparam logic [GAIN_W-1:0] FULL = {GAIN_W{1'b1}};

    p_enabled_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == PS_ENABLED) |-> (gain == FULL));

    p_idle_gain_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == PS_OFF || fsm_state == PS_STANDBY) |-> (gain == '0));

    p_clock_loss_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mclk_alive |=> (fsm_state == PS_OFF && gain == '0));

    p_standby_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == PS_STANDBY && mclk_alive && !mute_n) |=> (fsm_state == PS_STANDBY));

    p_no_direct_standby_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == PS_ENABLED) |=> (fsm_state != PS_STANDBY));

    p_fade_exit_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == PS_FADING && gain != '0) |=> (fsm_state != PS_STANDBY));

    p_ramp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == PS_FADING && !sample_valid) |=> (fsm_state != PS_FADING || $stable(gain)));

    p_ramp_falls_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == PS_FADING && sample_valid && gain != '0)
            |=> (fsm_state != PS_FADING || gain < $past(gain)));

    p_report_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_state != 2'd3);

    p_fade_reported_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == PS_FADING) |-> (pwr_state == 2'd2));
endmodule

bind pwr_seq_softmute pwr_seq_checker #(.GAIN_W(GAIN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mclk_alive   (mclk_alive),
    .mute_n       (mute_n),
    .sample_valid (sample_valid),
    .gain         (gain),
    .pwr_state    (pwr_state),
    .fsm_state    (fsm_state)
);

// File: tb/tb_pwr_seq_softmute.sv
module tb_pwr_seq_softmute;
    localparam int  GAIN_W = 16;
    localparam int  RAMP   = 800;
    localparam logic [GAIN_W-1:0] FULL = 16'hFFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mclk_alive = 1'b0;
    logic bclk = 1'b0;
    logic bclk_on = 1'b0;
    logic mute_n = 1'b0;
    logic sample_valid = 1'b0;
    logic [GAIN_W-1:0] gain;
    logic [1:0] pwr_state;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int bdiv = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwr_seq_softmute #(.GAIN_W(GAIN_W), .RAMP_LEN(RAMP), .BCLK_TIMEOUT(64)) dut (
        .clk(clk), .rst_n(rst_n), .mclk_alive(mclk_alive), .bclk_in(bclk),
        .mute_n(mute_n), .sample_valid(sample_valid), .gain(gain), .pwr_state(pwr_state)
    );

    always @(negedge clk) begin
        if (bclk_on) begin
            if (bdiv == 2) begin bdiv <= 0; bclk <= ~bclk; end
            else bdiv <= bdiv + 1;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !done) begin
            n_err = n_err + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    function automatic logic [GAIN_W-1:0] exp_gain(input int k);
        longint full = 65535;
        return GAIN_W'(full - (longint'(k) * full) / RAMP);
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_err = n_err + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic samp();
        sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    initial begin
        int k;
        void'($urandom(32'd7731));
        tick(5);
        check("R1 reset state", pwr_state, 0);
        check("R1 reset gain", gain, 0);
        rst_n = 1'b1;
        mclk_alive = 1'b1; mute_n = 1'b1;
        tick(100);
        check("R3 no bclk keeps Off", pwr_state, 0);

        bclk_on = 1'b1;
        tick(20);
        check("R2 off to enabled", pwr_state, 2);
        check("R2 full gain", gain, FULL);
        for (int i = 0; i < 5; i++) samp();
        check("R9 samples in enabled", gain, FULL);

        mute_n = 1'b0;
        tick(1);
        check("R10 fade reported enabled", pwr_state, 2);
        check("R5 no sample yet", gain, FULL);
        for (int i = 1; i <= RAMP; i++) begin
            tick($urandom % 3);
            samp();
            check("R5 ramp value", gain, exp_gain(i));
            if (i == RAMP) check("R6 still ramping at zero", pwr_state, 2);
        end
        tick(1);
        check("R6 standby after zero", pwr_state, 1);
        samp();
        check("R9 samples in standby", gain, 0);

        bclk_on = 1'b0;
        tick(100);
        check("R4 standby holds without bclk", pwr_state, 1);
        mute_n = 1'b1;
        tick(20);
        check("R4 no wake without bclk", pwr_state, 1);
        bclk_on = 1'b1;
        tick(20);
        check("R4 wake to enabled", pwr_state, 2);
        check("R4 wake gain", gain, FULL);

        for (int r = 0; r < 3; r++) begin
            k = 1 + int'($urandom % (RAMP - 1));
            mute_n = 1'b0;
            tick(1);
            for (int i = 0; i < k; i++) begin tick($urandom % 2); samp(); end
            check("R5 partial ramp", gain, exp_gain(k));
            mute_n = 1'b1;
            tick(1);
            check("R7 release gain", gain, FULL);
            check("R7 release state", pwr_state, 2);
        end

        bclk_on = 1'b0;
        tick(40);
        samp();
        check("R3 bclk not yet timed out", gain, FULL);
        tick(40);
        samp();
        check("R3 bclk timeout starts ramp", gain, exp_gain(1));
        for (int i = 2; i <= RAMP; i++) samp();
        check("R5 bclk ramp end", gain, 0);
        tick(1);
        check("R6 bclk ramp to standby", pwr_state, 1);
        bclk_on = 1'b1;
        tick(20);
        check("R4 wake after bclk return", pwr_state, 2);

        mute_n = 1'b0;
        tick(1);
        for (int i = 0; i < 10; i++) samp();
        mclk_alive = 1'b0;
        tick(1);
        check("R8 clock loss mid-ramp state", pwr_state, 0);
        check("R8 clock loss gain", gain, 0);
        mute_n = 1'b1; mclk_alive = 1'b1;
        tick(2);
        check("R2 off to enabled again", pwr_state, 2);
        mclk_alive = 1'b0;
        tick(1);
        check("R8 clock loss from enabled", pwr_state, 0);
        mute_n = 1'b0; mclk_alive = 1'b1;
        tick(2);
        check("R2 off to standby", pwr_state, 1);
        check("R2 standby gain", gain, 0);
        mclk_alive = 1'b0;
        tick(1);
        check("R8 clock loss from standby", pwr_state, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule